// File: doc/BRIEF.md
# Precise Exception Collector for a Five-Stage Pipeline

This block follows exceptions through an in-order pipeline of five stages: fetch, decode, execute, memory and write-back. Each instruction in flight carries a small exception vector made of a hit flag, the stage that raised the fault and a 3-bit cause. Any stage may mark an instruction, and faults may be detected out of program order. The vector is acted on at a single point only: the boundary between the memory and write-back stages. At that point the oldest instruction in flight is always the one being judged, so exceptions are taken in program order.

When a marked instruction reaches that boundary, the block drops its memory write in the same cycle. It loads no-ops into every stage behind it, so neither it nor any younger instruction writes memory or registers. It captures the exception PC, cause and stage. On the following cycle it requests a fetch redirect to a fixed trap address. If the faulting instruction sits in a branch delay slot, the saved PC is that of the branch, one instruction earlier. Older instructions in write-back retire normally.

The controller has two states. RUN is normal flow. REDIRECT lasts one cycle and issues the trap-vector fetch request. The transition RUN to REDIRECT is taken on a commit fault. The transition REDIRECT to RUN is unconditional. Fetched input that arrives during REDIRECT is discarded, because it comes from the wrong path.

Top module: `pec_collector`

## Requirements
- R1: After reset, mem_wr_en, wb_valid, wb_wr_en and redirect_valid are 0, trap_cause is 0 and trap_stage is 0.
- R2: Without faults, an instruction presented on the fetch inputs in cycle c appears in write-back in cycle c+4 with its own PC: wb_valid is 1 and wb_wr_en equals its register-write flag. mem_wr_en is 1 in cycle c+3 exactly when its store flag is set.
- R3: A fault is recorded with a stage code and a cause code. Stage codes are fetch 0, decode 1, execute 2, memory 3. Cause codes are page fault 1, protection 2, misaligned 3, illegal opcode 4, signed overflow 5. The raw 2-bit fetch and memory fault inputs use codes 1 to 3 directly, and 0 means no fault.
- R4: Once an instruction is marked, any later fault reported against it in a later stage is ignored, and its first stage and cause are the ones reported.
- R5: In the cycle a marked instruction is in the memory stage, mem_wr_en is 0 for it, and it never reaches write-back.
- R6: No instruction younger than the faulting one produces mem_wr_en or wb_valid.
- R7: Every instruction older than the faulting one retires in write-back and performs its memory write normally.
- R8: When a younger instruction faults earlier in time than an older one, the older instruction's exception is the one taken.
- R9: redirect_valid is 1 for exactly one cycle, the cycle after the faulting instruction leaves memory, with redirect_pc equal to the trap address. trap_epc, trap_cause and trap_stage change only in that cycle and hold their values afterwards.
- R10: trap_epc is the faulting instruction's PC. If the instruction is marked as a branch delay slot, trap_epc is that PC minus the instruction size.
- R11: An instruction presented on the fetch inputs in the redirect cycle is discarded and never reaches memory or write-back.
- R12: Fault inputs raised against a stage that holds no valid instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | 1 | A fetched instruction is presented |
| fe_pc | input | PC_W | PC of the fetched instruction |
| fe_in_slot | input | 1 | Fetched instruction sits in a branch delay slot |
| fe_store | input | 1 | Fetched instruction writes memory |
| fe_regwr | input | 1 | Fetched instruction writes a register |
| fe_fault | input | 2 | Fetch fault: 0 none, 1 page, 2 protection, 3 misaligned |
| dec_illegal | input | 1 | Illegal opcode for the instruction in decode |
| exe_overflow | input | 1 | Signed overflow for the instruction in execute |
| mem_fault | input | 2 | Memory fault: 0 none, 1 page, 2 protection, 3 misaligned |
| mem_wr_en | output | 1 | Memory write permitted for the instruction in memory |
| wb_valid | output | 1 | A valid instruction is retiring in write-back |
| wb_pc | output | PC_W | PC of the retiring instruction |
| wb_wr_en | output | 1 | Register write for the retiring instruction |
| redirect_valid | output | 1 | Fetch redirect request to the trap address |
| redirect_pc | output | PC_W | Trap address |
| trap_epc | output | PC_W | Saved exception PC |
| trap_cause | output | 3 | Saved cause code |
| trap_stage | output | 2 | Saved stage code |

## Verification
A wrong internal state in the exception vector shows up at the memory boundary. A lost mark lets a store through on mem_wr_en and lets the instruction reach write-back one cycle later. A stale or overwritten mark shows up as a wrong trap_cause or trap_stage in the redirect cycle, no more than four cycles after the faulting instruction was fetched. A controller stuck in REDIRECT, or flush logic that fails to clear the younger stages, shows within one to four cycles as a repeated redirect_valid or as a retirement of a squashed PC. The sweep places the fault on each of several instruction positions, in every stage, with and without a delay slot. It adds a younger fetch fault and a later fault on the same instruction, so both the ordering and the first-cause rule are observed at the ports.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [2:0] {
        CZ_NONE     = 3'd0,
        CZ_PAGE     = 3'd1,
        CZ_PROT     = 3'd2,
        CZ_ALIGN    = 3'd3,
        CZ_ILLEGAL  = 3'd4,
        CZ_OVERFLOW = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        SG_FETCH  = 2'd0,
        SG_DECODE = 2'd1,
        SG_EXEC   = 2'd2,
        SG_MEM    = 2'd3
    } stage_e;

    typedef struct packed {
        logic   hit;
        stage_e stg;
        cause_e cause;
    } xvec_t;

    typedef struct packed {
        logic  valid;
        logic  in_slot;
        logic  store;
        logic  regwr;
        xvec_t xv;
    } tag_t;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_REDIR = 1'b1
    } ctrl_e;

endpackage

// File: rtl/pec_mark.sv
module pec_mark
    import pec_pkg::*;
#(
    parameter stage_e STG = SG_FETCH
) (
    input  tag_t   tin,
    input  cause_e raw,
    output tag_t   tout
);

    // The first fault wins: a marked instruction keeps its vector.
    always_comb begin
        tout = tin;
        if (tin.valid && !tin.xv.hit && raw != CZ_NONE) begin
            tout.xv.hit   = 1'b1;
            tout.xv.stg   = STG;
            tout.xv.cause = raw;
        end
    end

endmodule

// File: rtl/pec_pipe.sv
module pec_pipe
    import pec_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int NSTG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            drop_fetch,
    input  tag_t            fe_tag,
    input  logic [PC_W-1:0] fe_pc,
    input  cause_e          raw [NSTG-1],
    output tag_t            mem_tag,
    output logic [PC_W-1:0] mem_pc,
    output tag_t            wb_tag,
    output logic [PC_W-1:0] wb_pc
);

    localparam int MEM_IX = NSTG - 2;
    localparam int WB_IX  = NSTG - 1;

    tag_t            q_tag [NSTG];
    logic [PC_W-1:0] q_pc  [NSTG];
    tag_t            m_tag [NSTG-1];

    // Stage j holds decode, execute, memory and write-back in turn.
    // Each stage except write-back can add a mark.
    for (genvar j = 0; j < NSTG - 1; j++) begin : g_mark
        pec_mark #(.STG(stage_e'(2'(j + 1)))) u_mark (
            .tin  (q_tag[j]),
            .raw  (raw[j]),
            .tout (m_tag[j])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int j = 0; j < NSTG; j++) begin
                q_tag[j] <= '0;
                q_pc[j]  <= '0;
            end
        end else begin
            q_tag[0] <= drop_fetch ? tag_t'('0) : fe_tag;
            q_pc[0]  <= fe_pc;
            for (int j = 1; j < NSTG; j++) begin
                q_tag[j] <= m_tag[j-1];
                q_pc[j]  <= q_pc[j-1];
            end
        end
    end

    assign mem_tag = m_tag[MEM_IX];
    assign mem_pc  = q_pc[MEM_IX];
    assign wb_tag  = q_tag[WB_IX];
    assign wb_pc   = q_pc[WB_IX];

endmodule

// File: rtl/pec_ctrl.sv
module pec_ctrl
    import pec_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] TRAP_VEC   = 'h80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  tag_t            mem_tag,
    input  logic [PC_W-1:0] mem_pc,
    output logic            flush,
    output logic            drop_fetch,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] trap_epc,
    output cause_e          trap_cause,
    output stage_e          trap_stage
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    ctrl_e st_q, st_d;
    logic  commit_fault;

    assign commit_fault = mem_tag.valid && mem_tag.xv.hit;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (commit_fault) st_d = ST_REDIR;
            ST_REDIR: st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        flush          = 1'b0;
        drop_fetch     = 1'b0;
        redirect_valid = 1'b0;
        unique case (st_q)
            ST_RUN:   flush = commit_fault;
            ST_REDIR: begin
                drop_fetch     = 1'b1;
                redirect_valid = 1'b1;
            end
            default:  ;
        endcase
    end

    assign redirect_pc = TRAP_VEC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_epc   <= '0;
            trap_cause <= CZ_NONE;
            trap_stage <= SG_FETCH;
        end else if (st_q == ST_RUN && commit_fault) begin
            trap_epc   <= mem_tag.in_slot ? mem_pc - STEP : mem_pc;
            trap_cause <= mem_tag.xv.cause;
            trap_stage <= mem_tag.xv.stg;
        end
    end

endmodule

// File: rtl/pec_collector.sv
module pec_collector
    import pec_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] TRAP_VEC   = 'h80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fe_valid,
    input  logic [PC_W-1:0] fe_pc,
    input  logic            fe_in_slot,
    input  logic            fe_store,
    input  logic            fe_regwr,
    input  logic [1:0]      fe_fault,
    input  logic            dec_illegal,
    input  logic            exe_overflow,
    input  logic [1:0]      mem_fault,
    output logic            mem_wr_en,
    output logic            wb_valid,
    output logic [PC_W-1:0] wb_pc,
    output logic            wb_wr_en,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] trap_epc,
    output logic [2:0]      trap_cause,
    output logic [1:0]      trap_stage
);

    localparam int NSTG = 4;

    tag_t            fe_raw_tag, fe_tag, mem_tag, wb_tag;
    logic [PC_W-1:0] mem_pc;
    cause_e          raw [NSTG-1];
    logic            flush, drop_fetch;
    cause_e          cause_q;
    stage_e          stage_q;

    always_comb begin
        fe_raw_tag         = '0;
        fe_raw_tag.valid   = fe_valid;
        fe_raw_tag.in_slot = fe_in_slot;
        fe_raw_tag.store   = fe_store;
        fe_raw_tag.regwr   = fe_regwr;
        raw[0] = dec_illegal  ? CZ_ILLEGAL  : CZ_NONE;
        raw[1] = exe_overflow ? CZ_OVERFLOW : CZ_NONE;
        raw[2] = cause_e'({1'b0, mem_fault});
    end

    pec_mark #(.STG(SG_FETCH)) u_fe_mark (
        .tin  (fe_raw_tag),
        .raw  (cause_e'({1'b0, fe_fault})),
        .tout (fe_tag)
    );

    pec_pipe #(.PC_W(PC_W), .NSTG(NSTG)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .drop_fetch (drop_fetch),
        .fe_tag     (fe_tag),
        .fe_pc      (fe_pc),
        .raw        (raw),
        .mem_tag    (mem_tag),
        .mem_pc     (mem_pc),
        .wb_tag     (wb_tag),
        .wb_pc      (wb_pc)
    );

    pec_ctrl #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .TRAP_VEC(TRAP_VEC)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_tag        (mem_tag),
        .mem_pc         (mem_pc),
        .flush          (flush),
        .drop_fetch     (drop_fetch),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .trap_epc       (trap_epc),
        .trap_cause     (cause_q),
        .trap_stage     (stage_q)
    );

    assign mem_wr_en  = mem_tag.valid && mem_tag.store && !mem_tag.xv.hit;
    assign wb_valid   = wb_tag.valid;
    assign wb_wr_en   = wb_tag.valid && wb_tag.regwr;
    assign trap_cause = cause_q;
    assign trap_stage = stage_q;

endmodule

// File: rtl/pec_collector_chk.sv
module pec_collector_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_wr_en,
    input logic            wb_valid,
    input logic            wb_wr_en,
    input logic            redirect_valid,
    input logic [PC_W-1:0] trap_epc,
    input logic [2:0]      trap_cause,
    input logic [1:0]      trap_stage
);

    // R9
    redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R9
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> ($stable(trap_epc) && $stable(trap_cause) && $stable(trap_stage)));

    // R3
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (trap_cause != 3'd0 && trap_cause <= 3'd5));

    // R6
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!wb_valid && !mem_wr_en));

    // R2
    regwr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wr_en |-> wb_valid);

endmodule

bind pec_collector pec_collector_chk #(.PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_wr_en      (mem_wr_en),
    .wb_valid       (wb_valid),
    .wb_wr_en       (wb_wr_en),
    .redirect_valid (redirect_valid),
    .trap_epc       (trap_epc),
    .trap_cause     (trap_cause),
    .trap_stage     (trap_stage)
);

// File: tb/pec_collector_bench.sv
module pec_collector_bench;

    localparam int          PC_W = 32;
    localparam logic [31:0] TRAP = 32'h80;
    localparam logic [31:0] BASE = 32'h100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fe_valid = 1'b0;
    logic [PC_W-1:0] fe_pc = '0;
    logic            fe_in_slot = 1'b0;
    logic            fe_store = 1'b0;
    logic            fe_regwr = 1'b0;
    logic [1:0]      fe_fault = '0;
    logic            dec_illegal = 1'b0;
    logic            exe_overflow = 1'b0;
    logic [1:0]      mem_fault = '0;
    logic            mem_wr_en, wb_valid, wb_wr_en, redirect_valid;
    logic [PC_W-1:0] wb_pc, redirect_pc, trap_epc;
    logic [2:0]      trap_cause;
    logic [1:0]      trap_stage;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pec_collector #(.PC_W(PC_W), .INSN_BYTES(4), .TRAP_VEC(TRAP)) u_pec_collector (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_pc(fe_pc),
        .fe_in_slot(fe_in_slot), .fe_store(fe_store), .fe_regwr(fe_regwr),
        .fe_fault(fe_fault), .dec_illegal(dec_illegal), .exe_overflow(exe_overflow),
        .mem_fault(mem_fault), .mem_wr_en(mem_wr_en), .wb_valid(wb_valid),
        .wb_pc(wb_pc), .wb_wr_en(wb_wr_en), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .trap_epc(trap_epc), .trap_cause(trap_cause),
        .trap_stage(trap_stage)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_store(input int i); return (i % 2) == 0; endfunction
    function automatic bit is_regwr(input int i); return (i % 3) != 0; endfunction

    task automatic clear_inputs();
        fe_valid = 0; fe_pc = '0; fe_in_slot = 0; fe_store = 0; fe_regwr = 0;
        fe_fault = 0; dec_illegal = 0; exe_overflow = 0; mem_fault = 0;
    endtask

    // k < 0: fault-free stream. Otherwise instruction k faults in stage s.
    task automatic run_case(input int k, input int s, input bit bds);
        int nfeed;
        int exp_cause;
        logic [31:0] exp_epc;
        nfeed = (k < 0) ? 10 : k + 5;
        exp_cause = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 5 : 1;
        exp_epc = BASE + 32'(4 * k) - (bds ? 32'd4 : 32'd0);
        for (int c = 0; c < nfeed + 8; c++) begin
            @(negedge clk);
            clear_inputs();
            if (c < nfeed) begin
                fe_valid   = 1;
                fe_pc      = BASE + 32'(4 * c);
                fe_in_slot = (c == k) && bds;
                fe_store   = is_store(c);
                fe_regwr   = is_regwr(c);
            end
            if (k >= 0) begin
                if (c == k + 1) fe_fault = 2'd3;     // younger faults earlier (R8)
                if (s == 0 && c == k)     fe_fault = 2'd2;
                if (s == 1 && c == k + 1) dec_illegal = 1;
                if (s == 2 && c == k + 2) exe_overflow = 1;
                if (s == 3 && c == k + 3) mem_fault = 2'd1;
                if (s < 3 && c == k + 3)  mem_fault = 2'd3;  // later fault ignored (R4)
            end
            #5;
            begin
                int im, iw;
                bit e_mw, e_wv;
                im = c - 3;
                iw = c - 4;
                e_mw = (im >= 0) && (im < nfeed) && (k < 0 || im < k) && is_store(im);
                e_wv = (iw >= 0) && (iw < nfeed) && (k < 0 || iw < k);
                if (k >= 0 && im == k)
                    chk("R5", "mem_wr_en of faulting insn", 32'(mem_wr_en), 32'd0);
                else if (k >= 0 && im > k)
                    chk("R6", "mem_wr_en of younger", 32'(mem_wr_en), 32'd0);
                else
                    chk(k < 0 ? "R2" : "R7", "mem_wr_en", 32'(mem_wr_en), 32'(e_mw));
                if (k >= 0 && iw >= k)
                    chk(iw == k + 4 ? "R11" : "R6", "wb_valid after squash",
                        32'(wb_valid), 32'd0);
                else
                    chk(k < 0 ? "R2" : "R7", "wb_valid", 32'(wb_valid), 32'(e_wv));
                chk("R2", "wb_wr_en", 32'(wb_wr_en), 32'(e_wv && is_regwr(iw)));
                if (e_wv) chk("R2", "wb_pc", wb_pc, BASE + 32'(4 * iw));
                chk("R9", "redirect_valid", 32'(redirect_valid),
                    32'(k >= 0 && c == k + 4));
                if (k >= 0 && (c == k + 4 || c == k + 7)) begin
                    if (c == k + 4) chk("R9", "redirect_pc", redirect_pc, TRAP);
                    chk("R10", "trap_epc", trap_epc, exp_epc);
                    chk(s < 3 ? "R4" : "R8", "trap_cause", 32'(trap_cause), 32'(exp_cause));
                    chk("R3", "trap_stage", 32'(trap_stage), 32'(s));
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #5;
        chk("R1", "mem_wr_en", 32'(mem_wr_en), 32'd0);
        chk("R1", "wb_valid", 32'(wb_valid), 32'd0);
        chk("R1", "wb_wr_en", 32'(wb_wr_en), 32'd0);
        chk("R1", "redirect_valid", 32'(redirect_valid), 32'd0);
        chk("R1", "trap_cause", 32'(trap_cause), 32'd0);
        chk("R1", "trap_stage", 32'(trap_stage), 32'd0);

        // R12: faults on an empty pipe do nothing.
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            clear_inputs();
            if (c < 6) begin
                fe_fault = 2'd1; dec_illegal = 1; exe_overflow = 1; mem_fault = 2'd2;
            end
            #5;
            chk("R12", "redirect_valid", 32'(redirect_valid), 32'd0);
            chk("R12", "wb_valid", 32'(wb_valid), 32'd0);
            chk("R12", "trap_cause", 32'(trap_cause), 32'd0);
        end

        run_case(-1, 0, 1'b0);
        for (int k = 0; k < 6; k++)
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 2; b++)
                    run_case(k, s, b[0]);
        run_case(-1, 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule